// File: doc/BRIEF.md
# Decoupled Sector Cache Hit Detector

This block decides whether a request address hits in a set-associative cache whose lines are split into sectors, where several address tags share one line and each sector records which of those tags owns it. Sectors that belong to different tags may interleave inside a single line. The block holds the tag store and the per-sector state for every set and way, and it compares one request per cycle. Each result reports hit or miss, the way involved and the kind of miss.

The request address is cut into fields. The lowest bits are the byte within a sector. Next come the sector number within the line, then the set number, then the tag-select bits. The remaining high bits are the stored tag. The tag-select bits choose one tag slot in every way of the set. The high bits are compared with that slot in all ways at once. A sector's memory address is its owner tag's line base plus the sector number times the sector size. Two independent write ports load tag slots and sector state. Refill sequencing, data storage and victim choice belong to the surrounding cache controller.

With the default parameters there are 16 sets, 2 ways, 4 tags per line, 8 sectors of 16 bytes and a 32-bit address. Sets, sectors per line and tags per line must be powers of two of at least 2. Sector size and way count must be powers of two.

Top module: `dsc_lookup`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_hit` are 0 and every tag slot and every sector is invalid, so the first lookup reports a major miss.
- R2: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high. In cycles after no request, `rsp_hit`, `rsp_kind` and `rsp_way` keep their previous values.
- R3: With default parameters the address fields are bits [3:0] byte (ignored), [6:4] sector, [10:7] set, [12:11] tag select and [31:13] compared tag. A change in the set or the tag-select bits moves the lookup to a different set or tag slot.
- R4: The tag-select value picks one of the four tag slots in each way. All ways of the set are compared in the same lookup.
- R5: A hit requires all of these: the selected tag slot is valid, its tag equals the request's high bits, the addressed sector is valid, and that sector's owner ID equals the tag-select value.
- R6: A tag slot written with its valid bit at 0 never matches, even when its stored tag equals the request's high bits.
- R7: When a way's selected tag matches but no way gives a full hit, the result is a minor miss. `rsp_way` is then the lowest-numbered way whose tag matched.
- R8: When no way's selected tag matches, the result is a major miss with `rsp_way` = 0.
- R9: `rsp_kind` encodes 0 = hit, 1 = minor miss, 2 = major miss. It never takes the value 3, and `rsp_hit` is 1 exactly when `rsp_kind` is 0.
- R10: Sectors of one line owned by different tags each hit only under their own owner's tag-select value. Under any other owner's value they give a minor miss.
- R11: When more than one way gives a full hit, `rsp_way` is the lowest-numbered one. A full hit in any way takes precedence over a tag match without a sector match in a lower way.
- R12: A write in the same cycle as a lookup does not affect that lookup. The next lookup sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W (32) | Request byte address |
| tag_wr_en | input | 1 | Tag slot write enable |
| tag_wr_set | input | SET_W (4) | Set of the tag slot written |
| tag_wr_way | input | WAY_W (1) | Way of the tag slot written |
| tag_wr_sel | input | SEL_W (2) | Tag slot index within the line |
| tag_wr_valid | input | 1 | Valid bit stored with the tag |
| tag_wr_value | input | TAG_W (19) | Tag value stored |
| sec_wr_en | input | 1 | Sector state write enable |
| sec_wr_set | input | SET_W (4) | Set of the sector written |
| sec_wr_way | input | WAY_W (1) | Way of the sector written |
| sec_wr_idx | input | SEC_W (3) | Sector number within the line |
| sec_wr_valid | input | 1 | Sector valid bit |
| sec_wr_owner | input | SEL_W (2) | Owner tag slot of the sector |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_hit | output | 1 | Full hit |
| rsp_kind | output | 2 | 0 hit, 1 minor miss, 2 major miss |
| rsp_way | output | WAY_W (1) | Way that hit, or way whose tag matched on a minor miss |

## Verification
A lookup and a write to the very entry that lookup reads can happen in the same clock cycle. The bench creates this case by invalidating a sector that fully hits in way 1 while a request for that sector is being sampled. It expects the result of that request to still show a hit in way 1. The request that follows must show a minor miss in way 0, the lowest way whose tag matched. This confirms that the result is computed from the contents the arrays held before the clock edge.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    LK_HIT   = 2'd0,
    LK_MINOR = 2'd1,
    LK_MAJOR = 2'd2
  } lookup_kind_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dsc_addr_split.sv
module dsc_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 4,
  parameter int unsigned SEC_W  = 3,
  parameter int unsigned SET_W  = 4,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned TAG_W  = ADDR_W - OFS_W - SEC_W - SET_W - SEL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SEC_W-1:0]  sec_idx,
  output logic [SET_W-1:0]  set_idx,
  output logic [SEL_W-1:0]  tag_sel,
  output logic [TAG_W-1:0]  tag_hi
);

  localparam int unsigned SEC_LO = OFS_W;
  localparam int unsigned SET_LO = SEC_LO + SEC_W;
  localparam int unsigned SEL_LO = SET_LO + SET_W;
  localparam int unsigned TAG_LO = SEL_LO + SEL_W;

  // byte-within-sector bits are dropped: they never influence the result
  assign sec_idx = addr[SEC_LO +: SEC_W];
  assign set_idx = addr[SET_LO +: SET_W];
  assign tag_sel = addr[SEL_LO +: SEL_W];
  assign tag_hi  = addr[TAG_LO +: TAG_W];

endmodule

// File: rtl/dsc_way_store.sv
module dsc_way_store #(
  parameter int unsigned SET_W = 4,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned SEC_W = 3,
  parameter int unsigned TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  // tag slot write
  input  logic             tag_we,
  input  logic [SET_W-1:0] tag_wset,
  input  logic [SEL_W-1:0] tag_wsel,
  input  logic             tag_wvalid,
  input  logic [TAG_W-1:0] tag_wvalue,
  // sector state write
  input  logic             sec_we,
  input  logic [SET_W-1:0] sec_wset,
  input  logic [SEC_W-1:0] sec_widx,
  input  logic             sec_wvalid,
  input  logic [SEL_W-1:0] sec_wowner,
  // read side
  input  logic [SET_W-1:0] rd_set,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic [SEC_W-1:0] rd_sec,
  output logic             rd_tag_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_sec_valid,
  output logic [SEL_W-1:0] rd_sec_owner
);

  localparam int unsigned TAG_N = 1 << (SET_W + SEL_W);
  localparam int unsigned SEC_N = 1 << (SET_W + SEC_W);

  logic [TAG_N-1:0] tag_vld_q, tag_vld_d;
  logic [SEC_N-1:0] sec_vld_q, sec_vld_d;
  logic [TAG_W-1:0] tag_val_q [TAG_N];
  logic [SEL_W-1:0] sec_own_q [SEC_N];

  logic [SET_W+SEL_W-1:0] tag_widx, tag_ridx;
  logic [SET_W+SEC_W-1:0] sec_widx_f, sec_ridx;

  assign tag_widx   = {tag_wset, tag_wsel};
  assign tag_ridx   = {rd_set, rd_sel};
  assign sec_widx_f = {sec_wset, sec_widx};
  assign sec_ridx   = {rd_set, rd_sec};

  // valid bits: next state
  always_comb begin
    tag_vld_d = tag_vld_q;
    sec_vld_d = sec_vld_q;
    if (tag_we) tag_vld_d[tag_widx]   = tag_wvalid;
    if (sec_we) sec_vld_d[sec_widx_f] = sec_wvalid;
  end

  // valid bits: registers with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_vld_q <= '0;
      sec_vld_q <= '0;
    end else begin
      tag_vld_q <= tag_vld_d;
      sec_vld_q <= sec_vld_d;
    end
  end

  // payload fields are qualified by the valid bits, so they carry no reset
  always_ff @(posedge clk) begin
    if (tag_we) tag_val_q[tag_widx]   <= tag_wvalue;
    if (sec_we) sec_own_q[sec_widx_f] <= sec_wowner;
  end

  assign rd_tag_valid = tag_vld_q[tag_ridx];
  assign rd_tag       = tag_val_q[tag_ridx];
  assign rd_sec_valid = sec_vld_q[sec_ridx];
  assign rd_sec_owner = sec_own_q[sec_ridx];

endmodule

// File: rtl/dsc_way_match.sv
module dsc_way_match #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned TAG_W = 19
) (
  input  logic [TAG_W-1:0] req_tag,
  input  logic [SEL_W-1:0] req_sel,
  input  logic             slot_valid,
  input  logic [TAG_W-1:0] slot_tag,
  input  logic             sec_valid,
  input  logic [SEL_W-1:0] sec_owner,
  output logic             tag_match,
  output logic             full_match
);

  // the owner ID of a sector names the tag slot, which is the tag-select value
  assign tag_match  = slot_valid && (slot_tag == req_tag);
  assign full_match = tag_match && sec_valid && (sec_owner == req_sel);

endmodule

// File: rtl/dsc_lookup.sv
module dsc_lookup
  import dsc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned SECTOR_BYTES  = 16,
  parameter int unsigned SECTORS       = 8,
  parameter int unsigned SETS          = 16,
  parameter int unsigned WAYS          = 2,
  parameter int unsigned TAGS_PER_LINE = 4,
  localparam int unsigned OFS_W = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 0,
  localparam int unsigned SEC_W = $clog2(SECTORS),
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned SEL_W = $clog2(TAGS_PER_LINE),
  localparam int unsigned WAY_W = idx_width(WAYS),
  localparam int unsigned TAG_W = ADDR_W - OFS_W - SEC_W - SET_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              tag_wr_en,
  input  logic [SET_W-1:0]  tag_wr_set,
  input  logic [WAY_W-1:0]  tag_wr_way,
  input  logic [SEL_W-1:0]  tag_wr_sel,
  input  logic              tag_wr_valid,
  input  logic [TAG_W-1:0]  tag_wr_value,
  input  logic              sec_wr_en,
  input  logic [SET_W-1:0]  sec_wr_set,
  input  logic [WAY_W-1:0]  sec_wr_way,
  input  logic [SEC_W-1:0]  sec_wr_idx,
  input  logic              sec_wr_valid,
  input  logic [SEL_W-1:0]  sec_wr_owner,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_kind,
  output logic [WAY_W-1:0]  rsp_way
);

  logic [SEC_W-1:0] req_sec;
  logic [SET_W-1:0] req_set;
  logic [SEL_W-1:0] req_sel;
  logic [TAG_W-1:0] req_tag;

  dsc_addr_split #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W),
    .SEC_W  (SEC_W),
    .SET_W  (SET_W),
    .SEL_W  (SEL_W),
    .TAG_W  (TAG_W)
  ) u_split (
    .addr    (req_addr),
    .sec_idx (req_sec),
    .set_idx (req_set),
    .tag_sel (req_sel),
    .tag_hi  (req_tag)
  );

  logic [WAYS-1:0] tag_hit_vec;
  logic [WAYS-1:0] full_hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic             slot_valid;
    logic [TAG_W-1:0] slot_tag;
    logic             sec_valid;
    logic [SEL_W-1:0] sec_owner;
    logic             tag_we_w;
    logic             sec_we_w;

    assign tag_we_w = tag_wr_en && (tag_wr_way == WAY_W'(w));
    assign sec_we_w = sec_wr_en && (sec_wr_way == WAY_W'(w));

    dsc_way_store #(
      .SET_W (SET_W),
      .SEL_W (SEL_W),
      .SEC_W (SEC_W),
      .TAG_W (TAG_W)
    ) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .tag_we       (tag_we_w),
      .tag_wset     (tag_wr_set),
      .tag_wsel     (tag_wr_sel),
      .tag_wvalid   (tag_wr_valid),
      .tag_wvalue   (tag_wr_value),
      .sec_we       (sec_we_w),
      .sec_wset     (sec_wr_set),
      .sec_widx     (sec_wr_idx),
      .sec_wvalid   (sec_wr_valid),
      .sec_wowner   (sec_wr_owner),
      .rd_set       (req_set),
      .rd_sel       (req_sel),
      .rd_sec       (req_sec),
      .rd_tag_valid (slot_valid),
      .rd_tag       (slot_tag),
      .rd_sec_valid (sec_valid),
      .rd_sec_owner (sec_owner)
    );

    dsc_way_match #(
      .SEL_W (SEL_W),
      .TAG_W (TAG_W)
    ) u_match (
      .req_tag    (req_tag),
      .req_sel    (req_sel),
      .slot_valid (slot_valid),
      .slot_tag   (slot_tag),
      .sec_valid  (sec_valid),
      .sec_owner  (sec_owner),
      .tag_match  (tag_hit_vec[w]),
      .full_match (full_hit_vec[w])
    );
  end

  // lowest-numbered way wins in both priority chains
  logic             any_full, any_tag;
  logic [WAY_W-1:0] full_way, tag_way;

  always_comb begin
    any_full = 1'b0;
    any_tag  = 1'b0;
    full_way = '0;
    tag_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (full_hit_vec[w]) begin
        any_full = 1'b1;
        full_way = WAY_W'(w);
      end
      if (tag_hit_vec[w]) begin
        any_tag = 1'b1;
        tag_way = WAY_W'(w);
      end
    end
  end

  lookup_kind_e     kind_new;
  logic [WAY_W-1:0] way_new;

  always_comb begin
    if (any_full) begin
      kind_new = LK_HIT;
      way_new  = full_way;
    end else if (any_tag) begin
      kind_new = LK_MINOR;
      way_new  = tag_way;
    end else begin
      kind_new = LK_MAJOR;
      way_new  = '0;
    end
  end

  // result register: next state
  logic             valid_q, valid_d;
  logic             hit_q, hit_d;
  lookup_kind_e     kind_q, kind_d;
  logic [WAY_W-1:0] way_q, way_d;

  always_comb begin
    valid_d = req_valid;
    hit_d   = hit_q;
    kind_d  = kind_q;
    way_d   = way_q;
    if (req_valid) begin
      hit_d  = (kind_new == LK_HIT);
      kind_d = kind_new;
      way_d  = way_new;
    end
  end

  // result register: state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      kind_q  <= LK_HIT;
      way_q   <= '0;
    end else begin
      valid_q <= valid_d;
      hit_q   <= hit_d;
      kind_q  <= kind_d;
      way_q   <= way_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_hit   = hit_q;
  assign rsp_kind  = kind_q;
  assign rsp_way   = way_q;

endmodule

// File: rtl/dsc_lookup_chk.sv
module dsc_lookup_chk #(
  parameter int unsigned WAY_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [1:0]       rsp_kind,
  input logic [WAY_W-1:0] rsp_way
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2

  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2

  AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_hit) && $stable(rsp_kind) && $stable(rsp_way))); // R2

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'd3)); // R9

  AST_HIT_FLAG_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit == (rsp_kind == 2'd0))); // R9

  AST_MAJOR_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd2) |-> (rsp_way == '0)); // R8

endmodule

bind dsc_lookup dsc_lookup_chk #(.WAY_W(WAY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_kind  (rsp_kind),
  .rsp_way   (rsp_way)
);

// File: tb/dsc_lookup_tb_top.sv
module dsc_lookup_tb_top;

  localparam int unsigned CLK_HALF = 2; // 250 MHz
  localparam logic [1:0] K_HIT = 2'd0, K_MIN = 2'd1, K_MAJ = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        tag_wr_en;
  logic [3:0]  tag_wr_set;
  logic [0:0]  tag_wr_way;
  logic [1:0]  tag_wr_sel;
  logic        tag_wr_valid;
  logic [18:0] tag_wr_value;
  logic        sec_wr_en;
  logic [3:0]  sec_wr_set;
  logic [0:0]  sec_wr_way;
  logic [2:0]  sec_wr_idx;
  logic        sec_wr_valid;
  logic [1:0]  sec_wr_owner;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [1:0]  rsp_kind;
  logic [0:0]  rsp_way;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #(CLK_HALF) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  dsc_lookup dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_addr (req_addr),
    .tag_wr_en (tag_wr_en), .tag_wr_set (tag_wr_set), .tag_wr_way (tag_wr_way),
    .tag_wr_sel (tag_wr_sel), .tag_wr_valid (tag_wr_valid), .tag_wr_value (tag_wr_value),
    .sec_wr_en (sec_wr_en), .sec_wr_set (sec_wr_set), .sec_wr_way (sec_wr_way),
    .sec_wr_idx (sec_wr_idx), .sec_wr_valid (sec_wr_valid), .sec_wr_owner (sec_wr_owner),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_kind (rsp_kind), .rsp_way (rsp_way)
  );

  typedef struct packed {
    logic [18:0] tag;
    logic [1:0]  sel;
    logic [3:0]  set;
    logic [2:0]  sec;
    logic [1:0]  kind;
    logic        way;
  } vec_t;

  // lookups against the set-3 contents loaded in the initial block
  localparam int unsigned NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{19'h1A2B3, 2'd1, 4'd3, 3'd0, 2'd0, 1'b0},  // R5 R10 own sector of tag slot 1
    '{19'h1A2B3, 2'd1, 4'd3, 3'd2, 2'd0, 1'b0},  // R10 second sector, same owner
    '{19'h1A2B3, 2'd1, 4'd3, 3'd1, 2'd1, 1'b0},  // R10 R7 sector owned by slot 2
    '{19'h00055, 2'd2, 4'd3, 3'd1, 2'd0, 1'b0},  // R10 interleaved owner hits
    '{19'h00055, 2'd2, 4'd3, 3'd0, 2'd1, 1'b0},  // R7 owner mismatch
    '{19'h1A2B3, 2'd1, 4'd3, 3'd3, 2'd1, 1'b0},  // R7 invalid sector
    '{19'h00007, 2'd1, 4'd3, 3'd5, 2'd0, 1'b1},  // R4 hit in way 1
    '{19'h00007, 2'd1, 4'd3, 3'd0, 2'd1, 1'b1},  // R7 minor in way 1
    '{19'h00123, 2'd3, 4'd3, 3'd0, 2'd2, 1'b0},  // R6 invalid tag slot
    '{19'h1A2B3, 2'd2, 4'd3, 3'd0, 2'd2, 1'b0},  // R4 other slot selected
    '{19'h1A2B3, 2'd1, 4'd4, 3'd0, 2'd2, 1'b0},  // R3 other set
    '{19'h1A2B4, 2'd1, 4'd3, 3'd0, 2'd2, 1'b0},  // R8 tag differs
    '{19'h00055, 2'd2, 4'd3, 3'd4, 2'd1, 1'b0}   // R7 sector owned by slot 0
  };

  function automatic logic [31:0] mk_addr(input logic [18:0] t, input logic [1:0] s,
                                          input logic [3:0] st, input logic [2:0] sc,
                                          input logic [3:0] b);
    return {t, s, st, sc, b};
  endfunction

  task automatic check_bit(input string rq, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", rq, what, act, exp);
    end
  endtask

  task automatic check_rsp(input string rq, input logic [1:0] ek, input logic ew);
    total++;
    if (rsp_valid !== 1'b1 || rsp_kind !== ek || rsp_way !== ew || rsp_hit !== (ek == K_HIT)) begin
      bad++;
      $display("FAIL %s actual valid=%0b kind=%0d way=%0d hit=%0b expected valid=1 kind=%0d way=%0d hit=%0b",
               rq, rsp_valid, rsp_kind, rsp_way, rsp_hit, ek, ew, (ek == K_HIT));
    end
  endtask

  task automatic lookup(input logic [31:0] a, input string rq, input logic [1:0] ek, input logic ew);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(rq, ek, ew);
  endtask

  task automatic put_tag(input logic [3:0] st, input logic w, input logic [1:0] s,
                         input logic v, input logic [18:0] t);
    @(negedge clk);
    tag_wr_en = 1'b1; tag_wr_set = st; tag_wr_way = w; tag_wr_sel = s;
    tag_wr_valid = v; tag_wr_value = t;
    @(negedge clk);
    tag_wr_en = 1'b0;
  endtask

  task automatic put_sec(input logic [3:0] st, input logic w, input logic [2:0] i,
                         input logic v, input logic [1:0] o);
    @(negedge clk);
    sec_wr_en = 1'b1; sec_wr_set = st; sec_wr_way = w; sec_wr_idx = i;
    sec_wr_valid = v; sec_wr_owner = o;
    @(negedge clk);
    sec_wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0;
    tag_wr_en = 1'b0; tag_wr_set = '0; tag_wr_way = '0; tag_wr_sel = '0;
    tag_wr_valid = 1'b0; tag_wr_value = '0;
    sec_wr_en = 1'b0; sec_wr_set = '0; sec_wr_way = '0; sec_wr_idx = '0;
    sec_wr_valid = 1'b0; sec_wr_owner = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_bit("R1", "rsp_valid", rsp_valid, 1'b0);
    check_bit("R1", "rsp_hit", rsp_hit, 1'b0);
    lookup(mk_addr(19'h0, 2'd0, 4'd0, 3'd0, 4'd0), "R1 empty arrays", K_MAJ, 1'b0);

    // load set 3
    put_tag(4'd3, 1'b0, 2'd1, 1'b1, 19'h1A2B3);
    put_tag(4'd3, 1'b0, 2'd2, 1'b1, 19'h00055);
    put_tag(4'd3, 1'b0, 2'd3, 1'b0, 19'h00123);
    put_tag(4'd3, 1'b1, 2'd1, 1'b1, 19'h00007);
    put_sec(4'd3, 1'b0, 3'd0, 1'b1, 2'd1);
    put_sec(4'd3, 1'b0, 3'd1, 1'b1, 2'd2);
    put_sec(4'd3, 1'b0, 3'd2, 1'b1, 2'd1);
    put_sec(4'd3, 1'b0, 3'd4, 1'b1, 2'd0);
    put_sec(4'd3, 1'b1, 3'd5, 1'b1, 2'd1);
    put_sec(4'd3, 1'b1, 3'd0, 1'b1, 2'd3);

    for (int i = 0; i < NVEC; i++) begin
      lookup(mk_addr(VECS[i].tag, VECS[i].sel, VECS[i].set, VECS[i].sec, 4'd0),
             $sformatf("R5 vector %0d", i), VECS[i].kind, VECS[i].way);
    end

    // R3 byte-offset bits are ignored
    lookup(mk_addr(19'h1A2B3, 2'd1, 4'd3, 3'd0, 4'hF), "R3 byte offset", K_HIT, 1'b0);

    // R2 idle cycle: no strobe, previous result held
    @(negedge clk);
    check_bit("R2", "rsp_valid idle", rsp_valid, 1'b0);
    check_bit("R2", "rsp_hit held", rsp_hit, 1'b1);

    // R6 slot 3 becomes valid, sector 6 owned by slot 3
    put_tag(4'd3, 1'b0, 2'd3, 1'b1, 19'h00123);
    put_sec(4'd3, 1'b0, 3'd6, 1'b1, 2'd3);
    lookup(mk_addr(19'h00123, 2'd3, 4'd3, 3'd6, 4'd0), "R6 slot now valid", K_HIT, 1'b0);

    // R11 both ways fully hit: lowest way
    put_tag(4'd5, 1'b0, 2'd0, 1'b1, 19'h0ABCD);
    put_tag(4'd5, 1'b1, 2'd0, 1'b1, 19'h0ABCD);
    put_sec(4'd5, 1'b0, 3'd7, 1'b1, 2'd0);
    put_sec(4'd5, 1'b1, 3'd7, 1'b1, 2'd0);
    lookup(mk_addr(19'h0ABCD, 2'd0, 4'd5, 3'd7, 4'd0), "R11 two full hits", K_HIT, 1'b0);
    put_sec(4'd5, 1'b0, 3'd7, 1'b0, 2'd0);
    lookup(mk_addr(19'h0ABCD, 2'd0, 4'd5, 3'd7, 4'd0), "R11 full hit beats lower minor", K_HIT, 1'b1);

    // R12 write and lookup in the same cycle
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = mk_addr(19'h0ABCD, 2'd0, 4'd5, 3'd7, 4'd0);
    sec_wr_en = 1'b1; sec_wr_set = 4'd5; sec_wr_way = 1'b1; sec_wr_idx = 3'd7;
    sec_wr_valid = 1'b0; sec_wr_owner = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    sec_wr_en = 1'b0;
    check_rsp("R12 same-cycle write unseen", K_HIT, 1'b1);
    lookup(mk_addr(19'h0ABCD, 2'd0, 4'd5, 3'd7, 4'd0), "R12 write seen next", K_MIN, 1'b0);

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule